// File: doc/BRIEF.md
# Externally Synchronized Display Timing Controller

This block paces pixel output for a panel whose frame and line timing is set by an outside sync source. It runs on the external pixel clock and generates no sync timing of its own. A frame starts only when an external vertical sync edge arrives, and each line starts only when an external horizontal sync edge arrives. Until then the block waits in the matching blanking state for as long as it takes.

Each sync input is first captured on a selectable clock edge. Its polarity is then corrected, it passes through a synchronizer chain, and a rising-edge detector turns it into a single trigger. In the active region the block requests one pixel per clock from a pixel source and forwards it as RGB. It also drives an enable/key output that marks pixels matching a programmed chroma-key colour. Both the RGB and the enable/key outputs can be retimed to the falling clock edge.

Top module: `esd_timing_ctrl`

## Requirements
- R1: After reset the status output `state_o` reads 0 (vertical blank). `rgb_out` is 0, `pix_rd` and `frame_done` are 0, and `de_key` sits at its inactive level, which equals `key_low`. The status encoding is 0 = vertical blank, 1 = horizontal blank, 2 = active.
- R2: In vertical blank the block stays there without any time limit until a vertical sync edge arrives. Horizontal sync edges have no effect in this state.
- R3: A vertical sync edge presented just after clock edge k moves the status to horizontal blank at edge k+3, not before. This also resets the line count to the first line.
- R4: In horizontal blank the block waits without limit for a horizontal sync edge. Vertical sync edges have no effect in this state.
- R5: A horizontal sync edge presented just after edge m moves the status to active at edge m+3. The block then stays active for exactly `h_pixels` clocks, with `pix_rd` high in each of them.
- R6: The pixel accepted in an active clock appears on `rgb_out` after the next rising edge. `rgb_out` is 0 for every clock that follows a non-active clock.
- R7: The end of a line that is not the last line returns the status to horizontal blank. After `v_lines` lines the status returns to vertical blank, and `frame_done` is high for exactly the first clock of that vertical blank.
- R8: A sync held at its active level triggers only once. A line that ends while horizontal sync is still held leaves the block in horizontal blank.
- R9: With `vs_inv`/`hs_inv` set to 1, the matching sync input is treated as active-low: a low pulse on an input that idles high acts as the sync edge.
- R10: With `samp_fall` = 0 the syncs are captured on the rising clock edge only. With `samp_fall` = 1 they are captured on the falling edge, so a pulse present only around a falling edge is seen in that mode alone.
- R11: With `out_fall` = 1, `rgb_out` and `de_key` change half a clock later, on the falling edge after the rising edge that would update them when `out_fall` = 0.
- R12: With `key_en` = 1, `de_key` is active only for output pixels equal to `key_color`. With `key_en` = 0 it stays inactive. Active is high when `key_low` = 0 and low when `key_low` = 1.
- R13: With `ext_en` = 0 the block stays in vertical blank and ignores both syncs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | External sync operation enable |
| vs_inv | input | 1 | Treat vertical sync as active-low |
| hs_inv | input | 1 | Treat horizontal sync as active-low |
| samp_fall | input | 1 | Capture syncs on falling clock edge |
| out_fall | input | 1 | Update RGB and enable/key on falling clock edge |
| key_en | input | 1 | Enable chroma-key gating of `de_key` |
| key_low | input | 1 | `de_key` is active-low |
| key_color | input | RGB_W | Chroma-key colour compared against pixels |
| h_pixels | input | CNT_W | Active pixels per line |
| v_lines | input | CNT_W | Active lines per frame |
| ext_vs | input | 1 | External vertical sync |
| ext_hs | input | 1 | External horizontal sync |
| pix_rgb | input | RGB_W | Pixel from the pixel source |
| pix_rd | output | 1 | Pixel accepted this clock |
| rgb_out | output | RGB_W | RGB pixel output |
| de_key | output | 1 | Enable/key output |
| state_o | output | 2 | Current state (0 vblank, 1 hblank, 2 active) |
| frame_done | output | 1 | One-clock pulse on entry to vertical blank |

## Verification
A sync edge driven 2 ns after rising edge k changes the status at edge k+3: one synchronizer stage per edge, then the state register. The bench therefore checks the old state after two edges and the new state after the third. An accepted pixel is due on `rgb_out` one rising edge later. In falling-output mode it is due half a clock after that, so the bench samples 2 ns after the edge, where the old value must still show, and again 6 ns after the edge, where the new value must show. Sampling-edge tests use a pulse that starts 2 ns after a rising edge and ends 2 ns after the following falling edge, so only a falling-edge capture can see it.

// File: rtl/esd_pkg.sv
package esd_pkg;
   typedef enum logic [1:0] {
      ST_VBLANK = 2'd0,
      ST_HBLANK = 2'd1,
      ST_ACTIVE = 2'd2
   } esd_state_e;
endpackage

// File: rtl/esd_sync_in.sv
// One external sync input: edge-selectable capture, polarity fix,
// synchronizer chain and a single-pulse rising trigger.
module esd_sync_in #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic inv,
   input  logic fall,
   output logic trig
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("esd_sync_in: STAGES must be at least 2");
      end
   endgenerate

   logic              neg_q;
   logic              samp;
   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= raw;
   end

   assign samp = (fall ? neg_q : raw) ^ inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], samp};
         prev  <= chain[STAGES-1];
      end
   end

   assign trig = chain[STAGES-1] & ~prev;

   // A held level yields one trigger only
   assert_single_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !trig);
endmodule

// File: rtl/esd_seq.sv
// Blanking / active sequencer driven purely by external sync triggers.
module esd_seq import esd_pkg::*; #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_en,
   input  logic             vs_trig,
   input  logic             hs_trig,
   input  logic [CNT_W-1:0] h_pixels,
   input  logic [CNT_W-1:0] v_lines,
   output esd_state_e       state,
   output logic             frame_done
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("esd_seq: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] px, ln;
   logic [CNT_W-1:0] h_last, v_last;

   assign h_last = h_pixels - ONE;
   assign v_last = v_lines - ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_VBLANK;
         px         <= '0;
         ln         <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (!ext_en) begin
            state <= ST_VBLANK;
         end else begin
            case (state)
               ST_VBLANK: if (vs_trig) begin
                  state <= ST_HBLANK;
                  ln    <= '0;
               end
               ST_HBLANK: if (hs_trig) begin
                  state <= ST_ACTIVE;
                  px    <= '0;
               end
               ST_ACTIVE: begin
                  if (px == h_last) begin
                     if (ln == v_last) begin
                        state      <= ST_VBLANK;
                        frame_done <= 1'b1;
                     end else begin
                        state <= ST_HBLANK;
                        ln    <= ln + ONE;
                     end
                  end else begin
                     px <= px + ONE;
                  end
               end
               default: state <= ST_VBLANK;
            endcase
         end
      end
   end

   assert_vblank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_VBLANK && !(ext_en && vs_trig)) |=> state == ST_VBLANK);

   assert_hblank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HBLANK && ext_en && !hs_trig) |=> state == ST_HBLANK);

   assert_px_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE) |-> px <= h_last);

   assert_done_in_vblank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> state == ST_VBLANK);

   assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
endmodule

// File: rtl/esd_out_stage.sv
// Pixel and enable/key output registers with rising/falling edge retiming.
module esd_out_stage #(
   parameter int RGB_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall,
   input  logic             act,
   input  logic [RGB_W-1:0] pix,
   input  logic [RGB_W-1:0] key_color,
   input  logic             key_en,
   input  logic             key_low,
   output logic [RGB_W-1:0] rgb_o,
   output logic             de_o
);
   generate
      if (RGB_W < 1) begin : g_bad_w
         $error("esd_out_stage: RGB_W must be positive");
      end
   endgenerate

   logic [RGB_W-1:0] rgb_p, rgb_n;
   logic             hit_p, hit_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rgb_p <= '0;
         hit_p <= 1'b0;
      end else begin
         rgb_p <= act ? pix : '0;
         hit_p <= key_en & act & (pix == key_color);
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rgb_n <= '0;
         hit_n <= 1'b0;
      end else begin
         rgb_n <= rgb_p;
         hit_n <= hit_p;
      end
   end

   assign rgb_o = fall ? rgb_n : rgb_p;
   assign de_o  = (fall ? hit_n : hit_p) ^ key_low;
endmodule

// File: rtl/esd_timing_ctrl.sv
module esd_timing_ctrl import esd_pkg::*; #(
   parameter int RGB_W       = 24,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_en,
   input  logic             vs_inv,
   input  logic             hs_inv,
   input  logic             samp_fall,
   input  logic             out_fall,
   input  logic             key_en,
   input  logic             key_low,
   input  logic [RGB_W-1:0] key_color,
   input  logic [CNT_W-1:0] h_pixels,
   input  logic [CNT_W-1:0] v_lines,
   input  logic             ext_vs,
   input  logic             ext_hs,
   input  logic [RGB_W-1:0] pix_rgb,
   output logic             pix_rd,
   output logic [RGB_W-1:0] rgb_out,
   output logic             de_key,
   output logic [1:0]       state_o,
   output logic             frame_done
);
   localparam int N_SYNC = 2;   // index 0: vertical, 1: horizontal

   logic [N_SYNC-1:0] raw_s, inv_s, trig_s;
   esd_state_e        state;

   assign raw_s = {ext_hs, ext_vs};
   assign inv_s = {hs_inv, vs_inv};

   generate
      for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
         esd_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_s[g]),
            .inv  (inv_s[g]),
            .fall (samp_fall),
            .trig (trig_s[g])
         );
      end
   endgenerate

   esd_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_en    (ext_en),
      .vs_trig   (trig_s[0]),
      .hs_trig   (trig_s[1]),
      .h_pixels  (h_pixels),
      .v_lines   (v_lines),
      .state     (state),
      .frame_done(frame_done)
   );

   assign pix_rd  = (state == ST_ACTIVE);
   assign state_o = state;

   esd_out_stage #(.RGB_W(RGB_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall     (out_fall),
      .act      (pix_rd),
      .pix      (pix_rgb),
      .key_color(key_color),
      .key_en   (key_en),
      .key_low  (key_low),
      .rgb_o    (rgb_out),
      .de_o     (de_key)
   );

   assert_ext_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_en |=> state_o == 2'd0);
endmodule

// File: tb/esd_timing_ctrl_test.sv
`timescale 1ns/1ps
module esd_timing_ctrl_test;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ext_en = 1'b1, vs_inv = 1'b0, hs_inv = 1'b0;
   logic        samp_fall = 1'b0, out_fall = 1'b0;
   logic        key_en = 1'b0, key_low = 1'b0;
   logic [23:0] key_color = '0;
   logic [11:0] h_pixels = 12'd4, v_lines = 12'd2;
   logic        ext_vs = 1'b0, ext_hs = 1'b0;
   logic [23:0] pix_rgb = '0;
   logic        pix_rd, de_key, frame_done;
   logic [23:0] rgb_out;
   logic [1:0]  state_o;

   int          n_chk = 0, n_bad = 0, idx = 0;
   logic [23:0] base = 24'h100000;
   bit          de_chk = 1'b0;

   esd_timing_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .vs_inv(vs_inv), .hs_inv(hs_inv),
      .samp_fall(samp_fall), .out_fall(out_fall), .key_en(key_en), .key_low(key_low),
      .key_color(key_color), .h_pixels(h_pixels), .v_lines(v_lines),
      .ext_vs(ext_vs), .ext_hs(ext_hs), .pix_rgb(pix_rgb), .pix_rd(pix_rd),
      .rgb_out(rgb_out), .de_key(de_key), .state_o(state_o), .frame_done(frame_done));

   always #4 clk = ~clk;   // 125 MHz

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // advance to 2 ns past the next rising edge and feed the pixel source
   task automatic step();
      @(posedge clk); #2;
      if (pix_rd) begin
         pix_rgb = base + 24'(idx);
         idx++;
      end else begin
         pix_rgb = 24'hA5A5A5;
      end
   endtask

   task automatic start();
      rst_n = 1'b0; ext_vs = vs_inv; ext_hs = hs_inv; idx = 0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic pulse_vs();
      step(); ext_vs = ~vs_inv;
      step(); ext_vs = vs_inv;
   endtask

   task automatic pulse_hs();
      step(); ext_hs = ~hs_inv;
      step(); ext_hs = hs_inv;
   endtask

   // from horizontal blank: pulse sync and land on the first active edge
   task automatic go_active();
      pulse_hs();
      step(); chk("R5 still hblank two edges after sync", state_o, 1);
      step(); chk("R5 active third edge", state_o, 2);
   endtask

   // called at first active edge; returns at the edge that leaves active
   task automatic active_line(int h);
      int s;
      s = idx - 1;
      for (int i = 0; i < h; i++) begin
         chk("R5 active state", state_o, 2);
         chk("R5 pixel request", pix_rd, 1);
         step();
         chk("R6 rgb follows accepted pixel", rgb_out, base + 24'(s + i));
         if (de_chk)
            chk("R12 key output", de_key,
                (key_en && (base + 24'(s + i) == key_color)) ^ key_low);
      end
   endtask

   task automatic t_reset();
      key_low = 1'b0; start();
      chk("R1 reset state", state_o, 0);
      chk("R1 reset rgb", rgb_out, 0);
      chk("R1 reset pix_rd", pix_rd, 0);
      chk("R1 reset frame_done", frame_done, 0);
      chk("R1 reset de_key", de_key, 0);
      key_low = 1'b1; start();
      chk("R1 reset de_key active-low", de_key, 1);
      key_low = 1'b0;
   endtask

   task automatic t_vwait();
      start();
      repeat (3) pulse_hs();
      repeat (300) step();
      chk("R2 vblank held, hsync ignored", state_o, 0);
   endtask

   task automatic t_frame();
      h_pixels = 12'd4; v_lines = 12'd2; start();
      pulse_vs();
      step(); chk("R3 vblank two edges after sync", state_o, 0);
      step(); chk("R3 hblank third edge", state_o, 1);
      repeat (50) step();
      chk("R4 hblank waits", state_o, 1);
      pulse_vs(); repeat (4) step();
      chk("R4 vsync ignored in hblank", state_o, 1);
      go_active();
      active_line(4);
      chk("R7 first line ends in hblank", state_o, 1);
      chk("R7 no frame_done mid frame", frame_done, 0);
      step();
      chk("R6 rgb zero in blanking", rgb_out, 0);
      chk("R5 no request in blanking", pix_rd, 0);
      go_active();
      active_line(4);
      chk("R7 last line ends in vblank", state_o, 0);
      chk("R7 frame_done pulse", frame_done, 1);
      step();
      chk("R7 frame_done one clock", frame_done, 0);
      chk("R6 rgb zero after frame", rgb_out, 0);
      repeat (100) step();
      chk("R2 vblank waits after frame", state_o, 0);
   endtask

   task automatic t_hold();
      h_pixels = 12'd4; v_lines = 12'd2; start();
      pulse_vs(); step(); step();
      step(); ext_hs = 1'b1;
      step(); step(); step();
      chk("R8 held hsync starts line", state_o, 2);
      active_line(4);
      repeat (30) step();
      chk("R8 held hsync no retrigger", state_o, 1);
      ext_hs = 1'b0; repeat (5) step();
      chk("R8 release no trigger", state_o, 1);
      go_active();
   endtask

   task automatic t_polarity();
      vs_inv = 1'b1; hs_inv = 1'b1; start();
      repeat (5) step();
      chk("R9 idle-high syncs no trigger", state_o, 0);
      pulse_vs(); step(); step();
      chk("R9 low vsync pulse", state_o, 1);
      pulse_hs(); step(); step();
      chk("R9 low hsync pulse", state_o, 2);
      vs_inv = 1'b0; hs_inv = 1'b0;
   endtask

   task automatic narrow_vs();
      step(); ext_vs = 1'b1; #4; ext_vs = 1'b0;
   endtask

   task automatic t_samp();
      samp_fall = 1'b0; start();
      narrow_vs(); repeat (5) step();
      chk("R10 rising capture misses narrow pulse", state_o, 0);
      samp_fall = 1'b1; start();
      narrow_vs(); step(); step();
      chk("R10 falling capture latency", state_o, 0);
      step();
      chk("R10 falling capture sees pulse", state_o, 1);
      samp_fall = 1'b0;
   endtask

   task automatic t_oedge();
      out_fall = 1'b1; key_en = 1'b1; key_low = 1'b0; key_color = base;
      h_pixels = 12'd4; v_lines = 12'd1; start();
      pulse_vs(); step(); step();
      go_active();
      step();
      chk("R11 rgb unchanged after rising edge", rgb_out, 0);
      chk("R11 key unchanged after rising edge", de_key, 0);
      #4;
      chk("R11 rgb after falling edge", rgb_out, base);
      chk("R11 key after falling edge", de_key, 1);
      step();
      chk("R11 rgb holds through rising edge", rgb_out, base);
      #4;
      chk("R11 second pixel after falling edge", rgb_out, base + 24'd1);
      chk("R11 key drops on mismatch", de_key, 0);
      out_fall = 1'b0; key_en = 1'b0;
   endtask

   task automatic key_run(bit en, bit low);
      key_en = en; key_low = low; key_color = base + 24'd2;
      h_pixels = 12'd4; v_lines = 12'd1; start();
      pulse_vs(); step(); step();
      go_active();
      de_chk = 1'b1; active_line(4); de_chk = 1'b0;
      step();
      chk("R12 key inactive in blanking", de_key, low);
   endtask

   task automatic t_key();
      key_run(1'b1, 1'b0);
      key_run(1'b1, 1'b1);
      key_run(1'b0, 1'b0);
      key_en = 1'b0; key_low = 1'b0;
   endtask

   task automatic t_mode();
      ext_en = 1'b0; start();
      pulse_vs(); repeat (5) step();
      chk("R13 vsync ignored when disabled", state_o, 0);
      pulse_hs(); repeat (5) step();
      chk("R13 hsync ignored when disabled", state_o, 0);
      ext_en = 1'b1;
   endtask

   initial begin
      t_reset();
      t_vwait();
      t_frame();
      t_hold();
      t_polarity();
      t_samp();
      t_oedge();
      t_key();
      t_mode();
      summary();
      $finish;
   end
endmodule